// File: doc/BRIEF.md
# Exception status save/restore unit

This block is the processor's status slice: it holds the live status word, the copy saved on exception entry, and the copy saved on break entry. It also holds the interrupt enable mask. Single-cycle pulses from the pipeline signal exception entry, break entry, exception return and break return. A control-register port lets software read any of the four registers and write any of them. Writes to the status word lose to the hardware events.

On a break return the status word comes back from the break copy. On an exception return the source depends on the current register set number held in the status word. Set 0 restores from the exception copy. Any other set restores from the shadow copy of the selected register set, which arrives on an input port. The block combines the irq lines with the enable mask and signals a request when the live interrupt enable bit permits one.

Top module: `exc_status_unit`

## Requirements
- R1: After reset the status word, the exception copy, the break copy and the enable mask are all zero.
- R2: Register selector 0 is status, 1 is the exception copy, 2 is the break copy and 3 is the enable mask. Readback is combinational. Selectors 4 to 7 read 0. Bits 31:24 of the three status words always read 0, and written values there are dropped. `crs_o` is status bits 15:10 and `pie_o` is status bit 0.
- R3: An exception entry copies status into the exception copy. It clears bits 2:0 of status (bit 0 interrupt enable, bit 1 user mode, bit 2 exception mode) and keeps every other bit.
- R4: A break entry copies status into the break copy and clears status bits 2:0, keeping every other bit.
- R5: A break return loads status from the break copy.
- R6: An exception return with status bits 15:10 equal to 0 loads status from the exception copy.
- R7: An exception return with status bits 15:10 nonzero loads status from `sstatus_i`, with bits 31:24 cleared.
- R8: The status word takes at most one update per cycle. The order of precedence is break return, exception return, break entry, exception entry, then a software write. Exception entry or break entry takes effect only when it wins. When it wins, its save overrides a software write to the same copy in that cycle.
- R9: `irq_pend_o` equals `irq_i` ANDed with the enable mask, combinationally. Mask bit n enables line n.
- R10: `irq_take_o` is 1 exactly when status bit 0 is 1 and `irq_pend_o` is nonzero.
- R11: With `HAS_IRQ_CTRL` = 0 the enable mask reads 0 whatever is written, and `irq_pend_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| exc_take_i | input | 1 | Exception entry pulse |
| brk_take_i | input | 1 | Break entry pulse |
| eret_i | input | 1 | Exception return pulse |
| bret_i | input | 1 | Break return pulse |
| csr_we_i | input | 1 | Software write strobe |
| csr_addr_i | input | 3 | Register selector |
| csr_wdata_i | input | 32 | Software write data |
| csr_rdata_o | output | 32 | Readback of the selected register |
| sstatus_i | input | 32 | Shadow status copy of the selected register set |
| irq_i | input | IRQ_N | Interrupt request lines |
| status_o | output | 32 | Live status word |
| pie_o | output | 1 | Live interrupt enable bit |
| crs_o | output | 6 | Current register set number |
| irq_pend_o | output | IRQ_N | Enabled pending interrupts |
| irq_take_o | output | 1 | Interrupt request to the pipeline |

## Verification
Assertions check on every cycle each save and restore path: the break copy and the exception copy capture the prior status, returns restore from the right source, bits 31:24 stay zero, a break return always wins, and pending lines stay a subset of the raw lines. Only the bench's scenarios can show several things. One is that the precedence chain resolves every mix of simultaneous pulses and writes. Another is that the readback mux and the selector decoding are correct, including the unused selectors. A third is that a software write to a copy survives when its save loses arbitration. The last is that a build without the interrupt controller ignores writes to the mask.

// File: rtl/exc_pkg.sv
package exc_pkg;
   localparam int WORD_W    = 32;
   localparam int CRS_LO    = 10;
   localparam int CRS_W     = 6;
   localparam int ADDR_W    = 3;
   localparam logic [WORD_W-1:0] LIVE_MASK = 32'h00FF_FFFF;
   localparam logic [WORD_W-1:0] ENTRY_CLR = 32'h0000_0007;

   typedef enum logic [ADDR_W-1:0] {
      SEL_STATUS  = 3'd0,
      SEL_ESAVE   = 3'd1,
      SEL_BSAVE   = 3'd2,
      SEL_IMASK   = 3'd3
   } csr_sel_e;

   typedef enum logic [2:0] {
      EV_NONE  = 3'd0,
      EV_SWWR  = 3'd1,
      EV_EXC   = 3'd2,
      EV_BRK   = 3'd3,
      EV_ERET  = 3'd4,
      EV_BRET  = 3'd5
   } st_ev_e;
endpackage

// File: rtl/exc_event_arb.sv
module exc_event_arb
   import exc_pkg::*;
(
   input  logic   exc_take_i,
   input  logic   brk_take_i,
   input  logic   eret_i,
   input  logic   bret_i,
   input  logic   sw_wr_i,
   output st_ev_e ev_o
);
   always_comb begin
      if (bret_i)           ev_o = EV_BRET;
      else if (eret_i)      ev_o = EV_ERET;
      else if (brk_take_i)  ev_o = EV_BRK;
      else if (exc_take_i)  ev_o = EV_EXC;
      else if (sw_wr_i)     ev_o = EV_SWWR;
      else                  ev_o = EV_NONE;
   end
endmodule

// File: rtl/exc_status_regs.sv
module exc_status_regs
   import exc_pkg::*;
#(
   parameter int W = WORD_W
) (
   input  logic         clk,
   input  logic         rst_n,
   input  st_ev_e       ev_i,
   input  logic         esave_wr_i,
   input  logic         bsave_wr_i,
   input  logic [W-1:0] wdata_i,
   input  logic [W-1:0] sstatus_i,
   output logic [W-1:0] status_o,
   output logic [W-1:0] esave_o,
   output logic [W-1:0] bsave_o
);
   localparam logic [W-1:0] MASK = LIVE_MASK[W-1:0];
   localparam logic [W-1:0] CLR  = ENTRY_CLR[W-1:0];

   generate
      if (W != WORD_W) begin : g_bad_width
         $error("exc_status_regs: W must equal WORD_W");
      end
   endgenerate

   logic [W-1:0]     status_q, esave_q, bsave_q, status_d;
   logic [CRS_W-1:0] crs;

   assign crs = status_q[CRS_LO +: CRS_W];

   always_comb begin
      unique case (ev_i)
         EV_BRET: status_d = bsave_q;
         EV_ERET: status_d = (crs == '0) ? esave_q : (sstatus_i & MASK);
         EV_BRK,
         EV_EXC:  status_d = status_q & ~CLR;
         EV_SWWR: status_d = wdata_i & MASK;
         default: status_d = status_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= '0;
         esave_q  <= '0;
         bsave_q  <= '0;
      end else begin
         status_q <= status_d;
         if (ev_i == EV_EXC)   esave_q <= status_q;
         else if (esave_wr_i)  esave_q <= wdata_i & MASK;
         if (ev_i == EV_BRK)   bsave_q <= status_q;
         else if (bsave_wr_i)  bsave_q <= wdata_i & MASK;
      end
   end

   assign status_o = status_q;
   assign esave_o  = esave_q;
   assign bsave_o  = bsave_q;

   AST_EXC_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
      ev_i == EV_EXC |=> esave_q == $past(status_q) && status_q[2:0] == 3'b000); // R3
   AST_BRK_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
      ev_i == EV_BRK |=> bsave_q == $past(status_q) && status_q[2:0] == 3'b000); // R4
   AST_BRET_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
      ev_i == EV_BRET |=> status_q == $past(bsave_q)); // R5
   AST_ERET_ESAVE: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_i == EV_ERET && crs == '0) |=> status_q == $past(esave_q)); // R6
   AST_ERET_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_i == EV_ERET && crs != '0) |=> status_q == ($past(sstatus_i) & MASK)); // R7
   AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q & ~MASK) == '0 && (esave_q & ~MASK) == '0 && (bsave_q & ~MASK) == '0); // R2
endmodule

// File: rtl/exc_irq_bank.sv
module exc_irq_bank #(
   parameter int IRQ_N        = 32,
   parameter bit HAS_IRQ_CTRL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we_i,
   input  logic [IRQ_N-1:0] wdata_i,
   input  logic [IRQ_N-1:0] irq_i,
   input  logic             pie_i,
   output logic [IRQ_N-1:0] mask_o,
   output logic [IRQ_N-1:0] pend_o,
   output logic             take_o
);
   generate
      if (IRQ_N < 1 || IRQ_N > 32) begin : g_bad_n
         $error("exc_irq_bank: IRQ_N must be 1..32");
      end

      if (HAS_IRQ_CTRL) begin : g_ctrl
         logic [IRQ_N-1:0] mask_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    mask_q <= '0;
            else if (we_i) mask_q <= wdata_i;
         end
         assign mask_o = mask_q;
      end else begin : g_no_ctrl
         logic unused_nc;
         assign unused_nc = ^{we_i, wdata_i, clk};
         assign mask_o = '0;
      end
   endgenerate

   assign pend_o = irq_i & mask_o;
   assign take_o = pie_i & (|pend_o);

   AST_PEND_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_o & ~irq_i) == '0); // R9
   AST_TAKE_NEEDS_PIE: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |-> pie_i && pend_o != '0); // R10
endmodule

// File: rtl/exc_status_unit.sv
module exc_status_unit
   import exc_pkg::*;
#(
   parameter int IRQ_N        = 32,
   parameter bit HAS_IRQ_CTRL = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               exc_take_i,
   input  logic               brk_take_i,
   input  logic               eret_i,
   input  logic               bret_i,
   input  logic               csr_we_i,
   input  logic [ADDR_W-1:0]  csr_addr_i,
   input  logic [WORD_W-1:0]  csr_wdata_i,
   output logic [WORD_W-1:0]  csr_rdata_o,
   input  logic [WORD_W-1:0]  sstatus_i,
   input  logic [IRQ_N-1:0]   irq_i,
   output logic [WORD_W-1:0]  status_o,
   output logic               pie_o,
   output logic [CRS_W-1:0]   crs_o,
   output logic [IRQ_N-1:0]   irq_pend_o,
   output logic               irq_take_o
);
   st_ev_e            ev;
   logic              sel_status, sel_esave, sel_bsave, sel_imask;
   logic [WORD_W-1:0] status_w, esave_w, bsave_w;
   logic [IRQ_N-1:0]  imask_w;

   assign sel_status = csr_addr_i == SEL_STATUS;
   assign sel_esave  = csr_addr_i == SEL_ESAVE;
   assign sel_bsave  = csr_addr_i == SEL_BSAVE;
   assign sel_imask  = csr_addr_i == SEL_IMASK;

   exc_event_arb u_arb (
      .exc_take_i (exc_take_i),
      .brk_take_i (brk_take_i),
      .eret_i     (eret_i),
      .bret_i     (bret_i),
      .sw_wr_i    (csr_we_i && sel_status),
      .ev_o       (ev)
   );

   exc_status_regs #(.W(WORD_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .ev_i       (ev),
      .esave_wr_i (csr_we_i && sel_esave),
      .bsave_wr_i (csr_we_i && sel_bsave),
      .wdata_i    (csr_wdata_i),
      .sstatus_i  (sstatus_i),
      .status_o   (status_w),
      .esave_o    (esave_w),
      .bsave_o    (bsave_w)
   );

   exc_irq_bank #(.IRQ_N(IRQ_N), .HAS_IRQ_CTRL(HAS_IRQ_CTRL)) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (csr_we_i && sel_imask),
      .wdata_i (csr_wdata_i[IRQ_N-1:0]),
      .irq_i   (irq_i),
      .pie_i   (status_w[0]),
      .mask_o  (imask_w),
      .pend_o  (irq_pend_o),
      .take_o  (irq_take_o)
   );

   always_comb begin
      csr_rdata_o = '0;
      if (sel_status)     csr_rdata_o = status_w;
      else if (sel_esave) csr_rdata_o = esave_w;
      else if (sel_bsave) csr_rdata_o = bsave_w;
      else if (sel_imask) csr_rdata_o = WORD_W'(imask_w);
   end

   assign status_o = status_w;
   assign pie_o    = status_w[0];
   assign crs_o    = status_w[CRS_LO +: CRS_W];

   AST_BRET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      bret_i |-> ev == EV_BRET); // R8
   AST_ERET_OVER_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (eret_i && !bret_i) |-> ev == EV_ERET); // R8
endmodule

// File: tb/tb_exc_status_unit.sv
`timescale 1ns/1ps
module tb_exc_status_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        exc_take, brk_take, eret, bret, we;
   logic [2:0]  addr;
   logic [31:0] wdata, sstat, irq;
   logic [31:0] rdata, status, rdata_nc, status_nc;
   logic        pie, take, pie_nc, take_nc;
   logic [5:0]  crs, crs_nc;
   logic [31:0] pend, pend_nc;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   logic [31:0] m_st, m_es, m_bs, m_ie;
   string       st_tag;

   always #10 clk = ~clk;

   exc_status_unit dut (
      .clk(clk), .rst_n(rst_n), .exc_take_i(exc_take), .brk_take_i(brk_take),
      .eret_i(eret), .bret_i(bret), .csr_we_i(we), .csr_addr_i(addr),
      .csr_wdata_i(wdata), .csr_rdata_o(rdata), .sstatus_i(sstat), .irq_i(irq),
      .status_o(status), .pie_o(pie), .crs_o(crs), .irq_pend_o(pend), .irq_take_o(take)
   );

   exc_status_unit #(.HAS_IRQ_CTRL(1'b0)) dut_nc (
      .clk(clk), .rst_n(rst_n), .exc_take_i(exc_take), .brk_take_i(brk_take),
      .eret_i(eret), .bret_i(bret), .csr_we_i(we), .csr_addr_i(addr),
      .csr_wdata_i(wdata), .csr_rdata_o(rdata_nc), .sstatus_i(sstat), .irq_i(irq),
      .status_o(status_nc), .pie_o(pie_nc), .crs_o(crs_nc), .irq_pend_o(pend_nc),
      .irq_take_o(take_nc)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] f_read(input logic [2:0] a);
      case (a)
         3'd0: return m_st;
         3'd1: return m_es;
         3'd2: return m_bs;
         3'd3: return m_ie;
         default: return 32'h0;
      endcase
   endfunction

   // One cycle: drive at negedge, check combinational outputs, update model at the edge.
   task automatic cyc(input logic e, input logic b, input logic er, input logic br,
                      input logic w, input logic [2:0] a, input logic [31:0] wd,
                      input logic [31:0] ss, input logic [31:0] iq);
      logic [31:0] n_st, n_es, n_bs, n_ie, pe;
      int contend;
      @(negedge clk);
      chk(st_tag, status, m_st);
      chk("R2 crs_o", {26'h0, crs}, {26'h0, m_st[15:10]});
      chk("R2 pie_o", {31'h0, pie}, {31'h0, m_st[0]});
      exc_take = e; brk_take = b; eret = er; bret = br;
      we = w; addr = a; wdata = wd; sstat = ss; irq = iq;
      #5;
      chk("R2 readback", rdata, f_read(a));
      pe = iq & m_ie;
      chk("R9 pending", pend, pe);
      chk("R10 take", {31'h0, take}, {31'h0, m_st[0] & (|pe)});
      chk("R11 pending", pend_nc, 32'h0);
      if (a == 3'd3) chk("R11 mask read", rdata_nc, 32'h0);
      n_st = m_st; n_es = m_es; n_bs = m_bs; n_ie = m_ie;
      contend = int'(e) + int'(b) + int'(er) + int'(br) + int'(w && a == 3'd0);
      if (w && a == 3'd1) n_es = wd & 32'h00FF_FFFF;
      if (w && a == 3'd2) n_bs = wd & 32'h00FF_FFFF;
      if (w && a == 3'd3) n_ie = wd;
      if (br) begin
         n_st = m_bs; st_tag = "R5 bret";
      end else if (er) begin
         if (m_st[15:10] == 6'd0) begin n_st = m_es; st_tag = "R6 eret set0"; end
         else begin n_st = ss & 32'h00FF_FFFF; st_tag = "R7 eret shadow"; end
      end else if (b) begin
         n_bs = m_st; n_st = m_st & ~32'h7; st_tag = "R4 break entry";
      end else if (e) begin
         n_es = m_st; n_st = m_st & ~32'h7; st_tag = "R3 exception entry";
      end else if (w && a == 3'd0) begin
         n_st = wd & 32'h00FF_FFFF; st_tag = "R2 status write";
      end else st_tag = "R2 status hold";
      if (contend > 1) st_tag = {"R8 priority / ", st_tag};
      @(posedge clk);
      m_st = n_st; m_es = n_es; m_bs = n_bs; m_ie = n_ie;
   endtask

   task automatic idle();
      cyc(0, 0, 0, 0, 0, 3'd0, 32'h0, 32'h0, 32'h0);
   endtask

   task automatic rd(input logic [2:0] a);
      cyc(0, 0, 0, 0, 0, a, 32'h0, 32'h0, 32'h0);
   endtask

   initial begin
      #3_000_000;
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd7351));
      exc_take = 0; brk_take = 0; eret = 0; bret = 0; we = 0;
      addr = 0; wdata = 0; sstat = 0; irq = 0;
      m_st = 0; m_es = 0; m_bs = 0; m_ie = 0; st_tag = "R1 reset";
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1: every register reads zero after reset
      for (int k = 0; k < 4; k++) begin
         @(negedge clk); addr = 3'(k); #5;
         chk("R1 reset readback", rdata, 32'h0);
      end
      // R2: upper bits dropped, unused selectors read zero
      cyc(0, 0, 0, 0, 1, 3'd0, 32'hFFFF_FC0F, 0, 0);
      rd(3'd0); rd(3'd5); rd(3'd7);
      // R3 then R6: exception entry and return with set 0
      cyc(1, 0, 0, 0, 0, 3'd0, 0, 0, 0);
      rd(3'd1);
      cyc(0, 0, 0, 0, 1, 3'd0, 32'h0000_0003, 0, 0);
      cyc(0, 0, 1, 0, 0, 3'd0, 0, 32'h1234_5678, 0);
      // R7: nonzero set restores from the shadow input
      cyc(0, 0, 0, 0, 1, 3'd0, 32'h0000_2C01, 0, 0);
      cyc(0, 0, 1, 0, 0, 3'd0, 0, 32'hAB9C_DEF5, 0);
      // R4 then R5: break entry and return
      cyc(0, 0, 0, 0, 1, 3'd0, 32'h00C3_0417, 0, 0);
      cyc(0, 1, 0, 0, 0, 3'd2, 0, 0, 0);
      rd(3'd2);
      cyc(0, 0, 0, 1, 0, 3'd0, 0, 0, 0);
      // R8: every pulse at once, bret wins; then exception entry beats software copy write
      cyc(1, 1, 1, 1, 1, 3'd0, 32'h00FF_FFFF, 32'h0055_0000, 0);
      cyc(1, 0, 0, 0, 1, 3'd1, 32'h00AA_AAAA, 0, 0);
      rd(3'd1);
      cyc(1, 1, 0, 0, 1, 3'd1, 32'h0012_3456, 0, 0);
      rd(3'd1); rd(3'd2);
      // R9, R10, R11: mask writes and request gating
      cyc(0, 0, 0, 0, 1, 3'd3, 32'hF0F0_0001, 0, 32'hFFFF_FFFF);
      cyc(0, 0, 0, 0, 1, 3'd0, 32'h0000_0001, 0, 32'h0F0F_0001);
      cyc(0, 0, 0, 0, 0, 3'd3, 0, 0, 32'h8000_0000);
      cyc(0, 0, 0, 0, 0, 3'd3, 0, 0, 32'h0F0F_0FFE);
      idle();
      // Random mix of events, writes and irq patterns
      for (int i = 0; i < 3000; i++) begin
         logic [31:0] wd, ss, iq;
         logic [2:0]  a;
         wd = $urandom; ss = $urandom; iq = $urandom;
         a  = 3'($urandom_range(0, 7));
         if (($urandom & 3) == 0) wd[15:10] = 6'd0;
         cyc(($urandom & 7) == 0, ($urandom & 15) == 0, ($urandom & 7) == 0,
             ($urandom & 15) == 0, ($urandom & 1) == 1, a, wd, ss, iq);
      end
      idle();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule